// File: doc/BRIEF.md
# Crystal Oscillator Startup Controller

This block holds the control and status logic for an on-chip high-frequency oscillator. Software writes a configuration word made of a power-down bit, a single-ended select bit and a startup-time field. The block turns that word into an enable for the analog oscillator and into ownership flags for the two oscillator pins. A pin whose flag is low stays a general-purpose I/O. It also reports whether the clock is good or off.

A single-cycle timebase tick marks each 64 µs unit. After the oscillator is enabled, a unit counter runs on these ticks. The clock is declared good once the programmed number of units has passed and the analog core has shown an alive indication. If no alive indication arrives within a fixed maximum timeout, or if the oscillator later goes silent for a whole tick window, the block reports the oscillator as off (dead).

The block screens each configuration write as a whole and drops any write that breaks one of its rules:
- a switch between crystal and single-ended operation must go through the parked (powered-down, double-ended) setting;
- a re-enable must wait for the off status;
- a power-down is held back while downstream clock users still depend on this oscillator.

Top module: `xosc_start_ctrl`

## Requirements
- R1: After reset, osc_en, pin1_osc, pin2_osc and stat_good are 0, stat_off is 1, and the readback shows rd_off=1, rd_se=0, rd_stime=0.
- R2: Pin decode from the accepted (rd_off, rd_se) pair:
  - (0,0) is crystal mode: osc_en=1, pin1_osc=1, pin2_osc=1.
  - (0,1) and (1,1) are single-ended mode: osc_en=1, pin1_osc=1, pin2_osc=0.
  - (1,0) is parked: osc_en=0 and both pins are GPIO (pin1_osc=0, pin2_osc=0).
  - A pin flag of 1 means the oscillator owns the pin.
- R3: An accepted write that moves from parked to an enabled mode raises osc_en and clears stat_off, both visible in the cycle after the write edge.
- R4: With startup field N, stat_good rises on the (N+1)-th tick after the enable write, provided osc_alive has been high at some point since the enable. It stays 0 on every earlier tick.
- R5: With a startup field of zero, stat_good rises on the first tick after the enable when osc_alive is high.
- R6: If stat_good has not risen by the (2^TIME_W + TMO_EXTRA)-th tick after the enable, stat_off becomes 1 on that tick and stat_good stays 0, even if osc_alive then rises.
- R7: While good, if osc_alive stays low from one tick through the next tick, stat_good falls and stat_off rises on that second tick. osc_en is unchanged.
- R8: An accepted disable (enabled mode to parked) drops stat_good in the cycle after the write edge. stat_off stays 0 until the first tick at which osc_alive is low.
- R9: A write that would enable the oscillator while stat_off is 0 is ignored. A rejected write of any kind changes none of rd_off, rd_se or rd_stime.
- R10: A write that changes the single-ended bit is ignored unless either the current setting or the written setting is parked (off=1, se=0).
- R11: A disable write is ignored while pll_ref_osc=1 and pll_off=0.
- R12: A disable write is ignored while mclk_hs=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_off | input | 1 | Written power-down bit |
| cfg_se | input | 1 | Written single-ended select bit |
| cfg_stime | input | TIME_W | Written startup time in 64 µs units |
| tick | input | 1 | One-cycle pulse per 64 µs unit |
| osc_alive | input | 1 | Oscillator activity indication from the analog core |
| pll_ref_osc | input | 1 | PLL is enabled with this oscillator as reference |
| pll_off | input | 1 | PLL reports it is off |
| mclk_hs | input | 1 | Main clock is running from the high-speed source |
| osc_en | output | 1 | Enable to the analog oscillator |
| pin1_osc | output | 1 | First oscillator pin owned by the oscillator |
| pin2_osc | output | 1 | Second oscillator pin owned by the oscillator |
| stat_good | output | 1 | Clock good status |
| stat_off | output | 1 | Oscillator off or dead status |
| rd_off | output | 1 | Readback of accepted power-down bit |
| rd_se | output | 1 | Readback of accepted single-ended bit |
| rd_stime | output | TIME_W | Readback of accepted startup time |

## Verification
The bench drives every input on the falling edge. A write therefore lands on the next rising edge, and its effect on the readback, osc_en, the pin flags and stat_off is sampled at the following falling edge, one cycle after the strobe. Status changes that depend on the timebase (good, dead, timeout, off after disable) are due on the rising edge that samples the tick, so the bench raises tick for exactly one cycle and checks at the falling edge after it. The bench counts ticks itself to find the (N+1)-th and timeout ticks. A random phase of interlocked writes is compared with a bench model that advances only on those same edges.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

  typedef enum logic [1:0] {
    XM_PARK    = 2'd0,
    XM_CRYSTAL = 2'd1,
    XM_SINGLE  = 2'd2
  } xosc_mode_e;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAIT = 3'd1,
    ST_GOOD = 3'd2,
    ST_STOP = 3'd3,
    ST_DEAD = 3'd4
  } xosc_state_e;

  // Mode decode of the two control bits.
  function automatic xosc_mode_e f_mode(input logic off_b, input logic se_b);
    if (se_b)        return XM_SINGLE;
    else if (!off_b) return XM_CRYSTAL;
    else             return XM_PARK;
  endfunction

  function automatic logic f_is_park(input logic off_b, input logic se_b);
    return f_mode(off_b, se_b) == XM_PARK;
  endfunction

  function automatic logic f_osc_on(input logic off_b, input logic se_b);
    return f_mode(off_b, se_b) != XM_PARK;
  endfunction

  // A change of the single-ended bit must pass through the parked setting.
  function automatic logic f_mode_step_ok(input logic cur_off, input logic cur_se,
                                          input logic new_off, input logic new_se);
    return (cur_se == new_se) || f_is_park(cur_off, cur_se) || f_is_park(new_off, new_se);
  endfunction

endpackage

// File: rtl/xosc_cfg_regs.sv
module xosc_cfg_regs
  import xosc_pkg::*;
#(
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wr_off,
  input  logic              wr_se,
  input  logic [TIME_W-1:0] wr_stime,
  input  logic              stat_off,
  input  logic              pll_ref_osc,
  input  logic              pll_off,
  input  logic              mclk_hs,
  output logic              off_q,
  output logic              se_q,
  output logic [TIME_W-1:0] stime_q,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              acc_evt,
  output logic              rej_mode,
  output logic              rej_dis,
  output logic              rej_en
);

  logic on_now;
  logic on_new;
  logic dis_req;
  logic en_req;
  logic held_by_users;

  assign on_now        = f_osc_on(off_q, se_q);
  assign on_new        = f_osc_on(wr_off, wr_se);
  assign dis_req       = on_now && !on_new;
  assign en_req        = !on_now && on_new;
  assign held_by_users = mclk_hs || (pll_ref_osc && !pll_off);

  assign rej_mode  = wr && !f_mode_step_ok(off_q, se_q, wr_off, wr_se);
  assign rej_dis   = wr && dis_req && held_by_users;
  assign rej_en    = wr && en_req && !stat_off;
  assign acc_evt   = wr && !rej_mode && !rej_dis && !rej_en;
  assign start_evt = acc_evt && en_req;
  assign stop_evt  = acc_evt && dis_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= 1'b1;
      se_q    <= 1'b0;
      stime_q <= '0;
    end else if (acc_evt) begin
      off_q   <= wr_off;
      se_q    <= wr_se;
      stime_q <= wr_stime;
    end
  end

endmodule

// File: rtl/xosc_pin_map.sv
module xosc_pin_map
  import xosc_pkg::*;
(
  input  logic off_q,
  input  logic se_q,
  output logic osc_en,
  output logic pin1_osc,
  output logic pin2_osc
);

  xosc_mode_e mode;

  always_comb begin
    mode = f_mode(off_q, se_q);
    unique case (mode)
      XM_CRYSTAL: begin osc_en = 1'b1; pin1_osc = 1'b1; pin2_osc = 1'b1; end
      XM_SINGLE:  begin osc_en = 1'b1; pin1_osc = 1'b1; pin2_osc = 1'b0; end
      default:    begin osc_en = 1'b0; pin1_osc = 1'b0; pin2_osc = 1'b0; end
    endcase
  end

endmodule

// File: rtl/xosc_startup_seq.sv
module xosc_startup_seq
  import xosc_pkg::*;
#(
  parameter int TIME_W    = 6,
  parameter int TMO_EXTRA = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              osc_alive,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [TIME_W-1:0] stime,
  output logic              stat_good,
  output logic              stat_off,
  output logic              good_hit,
  output logic              tmo_hit,
  output logic              lost_hit,
  output logic              gone_hit
);

  localparam int TMO_UNITS = (1 << TIME_W) + TMO_EXTRA;
  localparam int CNT_W     = $clog2(TMO_UNITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_UNITS - 1);

  // Startup is due once the count of completed ticks reaches the field.
  function automatic logic f_due(input logic [CNT_W-1:0] c, input logic [TIME_W-1:0] n);
    return c >= {{(CNT_W-TIME_W){1'b0}}, n};
  endfunction

  xosc_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic             seen;
  logic             win;

  assign good_hit = (st == ST_WAIT) && tick && !stop_evt && f_due(cnt, stime) && (seen || osc_alive);
  assign tmo_hit  = (st == ST_WAIT) && tick && !stop_evt && !good_hit && (cnt == CNT_LAST);
  assign lost_hit = (st == ST_GOOD) && tick && !stop_evt && !(win || osc_alive);
  assign gone_hit = (st == ST_STOP) && tick && !osc_alive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_OFF;
      cnt  <= '0;
      seen <= 1'b0;
      win  <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF: begin
          if (start_evt) begin
            st   <= ST_WAIT;
            cnt  <= '0;
            seen <= 1'b0;
          end
        end
        ST_WAIT: begin
          seen <= seen || osc_alive;
          if (stop_evt) begin
            st <= ST_STOP;
          end else if (good_hit) begin
            st  <= ST_GOOD;
            win <= osc_alive;
          end else if (tmo_hit) begin
            st <= ST_DEAD;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GOOD: begin
          if (stop_evt)     st  <= ST_STOP;
          else if (lost_hit) st <= ST_DEAD;
          else if (tick)    win <= osc_alive;
          else              win <= win || osc_alive;
        end
        ST_DEAD: begin
          if (stop_evt) st <= ST_STOP;
        end
        ST_STOP: begin
          if (gone_hit) st <= ST_OFF;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign stat_good = (st == ST_GOOD);
  assign stat_off  = (st == ST_OFF) || (st == ST_DEAD);

endmodule

// File: rtl/xosc_start_ctrl.sv
module xosc_start_ctrl
  import xosc_pkg::*;
#(
  parameter int TIME_W    = 6,
  parameter int TMO_EXTRA = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_off,
  input  logic              cfg_se,
  input  logic [TIME_W-1:0] cfg_stime,
  input  logic              tick,
  input  logic              osc_alive,
  input  logic              pll_ref_osc,
  input  logic              pll_off,
  input  logic              mclk_hs,
  output logic              osc_en,
  output logic              pin1_osc,
  output logic              pin2_osc,
  output logic              stat_good,
  output logic              stat_off,
  output logic              rd_off,
  output logic              rd_se,
  output logic [TIME_W-1:0] rd_stime
);

  // Named internal events, visible to the bound checker.
  logic start_evt;
  logic stop_evt;
  logic acc_evt;
  logic rej_mode;
  logic rej_dis;
  logic rej_en;
  logic good_hit;
  logic tmo_hit;
  logic lost_hit;
  logic gone_hit;

  xosc_cfg_regs #(.TIME_W(TIME_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (cfg_wr),
    .wr_off     (cfg_off),
    .wr_se      (cfg_se),
    .wr_stime   (cfg_stime),
    .stat_off   (stat_off),
    .pll_ref_osc(pll_ref_osc),
    .pll_off    (pll_off),
    .mclk_hs    (mclk_hs),
    .off_q      (rd_off),
    .se_q       (rd_se),
    .stime_q    (rd_stime),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .acc_evt    (acc_evt),
    .rej_mode   (rej_mode),
    .rej_dis    (rej_dis),
    .rej_en     (rej_en)
  );

  xosc_pin_map u_pins (
    .off_q   (rd_off),
    .se_q    (rd_se),
    .osc_en  (osc_en),
    .pin1_osc(pin1_osc),
    .pin2_osc(pin2_osc)
  );

  xosc_startup_seq #(.TIME_W(TIME_W), .TMO_EXTRA(TMO_EXTRA)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .osc_alive(osc_alive),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .stime    (rd_stime),
    .stat_good(stat_good),
    .stat_off (stat_off),
    .good_hit (good_hit),
    .tmo_hit  (tmo_hit),
    .lost_hit (lost_hit),
    .gone_hit (gone_hit)
  );

endmodule

// File: rtl/xosc_start_ctrl_chk.sv
module xosc_start_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pll_ref_osc,
  input logic pll_off,
  input logic mclk_hs,
  input logic osc_en,
  input logic pin1_osc,
  input logic pin2_osc,
  input logic stat_good,
  input logic stat_off,
  input logic rd_off,
  input logic rd_se,
  input logic rej_mode
);

  // R1 / R7: good and off never together
  p_good_off_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_good && stat_off));

  // R2: second pin is only owned when the first is
  p_pin_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pin2_osc |-> pin1_osc);

  // R4: good only rises on a tick and only with the oscillator enabled
  p_good_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_good) |-> ($past(tick) && osc_en));

  // R7: a good-to-off drop with the oscillator still on happens at a tick
  p_dead_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stat_good) && osc_en) |-> (stat_off && $past(tick)));

  // R8: disabling clears good at once
  p_good_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> !stat_good);

  // R9: enable only after off status was present
  p_no_early_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(stat_off));

  // R10: a single-ended bit change touches the parked setting
  p_mode_via_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_se) |-> ((rd_off && !rd_se) || ($past(rd_off) && !$past(rd_se))));

  // R10: a rejected mode write leaves the select bit alone
  p_mode_rej_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rej_mode |=> $stable(rd_se));

  // R11: no disable while the PLL holds this reference
  p_pll_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pll_ref_osc) && !$past(pll_off) && $past(osc_en)) |-> osc_en);

  // R12: no disable while the main clock uses the high-speed source
  p_mclk_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mclk_hs) && $past(osc_en)) |-> osc_en);

endmodule

bind xosc_start_ctrl xosc_start_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .pll_ref_osc(pll_ref_osc),
  .pll_off    (pll_off),
  .mclk_hs    (mclk_hs),
  .osc_en     (osc_en),
  .pin1_osc   (pin1_osc),
  .pin2_osc   (pin2_osc),
  .stat_good  (stat_good),
  .stat_off   (stat_off),
  .rd_off     (rd_off),
  .rd_se      (rd_se),
  .rej_mode   (rej_mode)
);

// File: tb/sim_xosc_start_ctrl.sv
module sim_xosc_start_ctrl;

  localparam int TW  = 6;
  localparam int EXT = 8;
  localparam int TMO = (1 << TW) + EXT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0, cfg_off = 1'b0, cfg_se = 1'b0;
  logic [TW-1:0] cfg_stime = '0;
  logic          tick = 1'b0, osc_alive = 1'b0;
  logic          pll_ref_osc = 1'b0, pll_off = 1'b0, mclk_hs = 1'b0;
  logic          osc_en, pin1_osc, pin2_osc, stat_good, stat_off, rd_off, rd_se;
  logic [TW-1:0] rd_stime;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xosc_start_ctrl #(.TIME_W(TW), .TMO_EXTRA(EXT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_se(cfg_se),
    .cfg_stime(cfg_stime), .tick(tick), .osc_alive(osc_alive), .pll_ref_osc(pll_ref_osc),
    .pll_off(pll_off), .mclk_hs(mclk_hs), .osc_en(osc_en), .pin1_osc(pin1_osc),
    .pin2_osc(pin2_osc), .stat_good(stat_good), .stat_off(stat_off), .rd_off(rd_off),
    .rd_se(rd_se), .rd_stime(rd_stime)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected pin flags {osc_en,pin1,pin2} from the R2 table.
  function automatic int exp_pins(input bit o, input bit s);
    if (s)       return 3'b110;
    else if (!o) return 3'b111;
    else         return 3'b000;
  endfunction

  function automatic bit is_on(input bit o, input bit s);
    return s || !o;
  endfunction

  // Acceptance rule restated from R9..R12.
  function automatic bit exp_accept(input bit co, input bit cs, input bit no, input bit ns,
                                    input bit soff, input bit pu, input bit po, input bit mh);
    bit park_any;
    park_any = (co && !cs) || (no && !ns);
    if (cs != ns && !park_any) return 0;
    if (is_on(co, cs) && !is_on(no, ns) && (mh || (pu && !po))) return 0;
    if (!is_on(co, cs) && is_on(no, ns) && !soff) return 0;
    return 1;
  endfunction

  task automatic wr(input bit o, input bit s, input int st);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_off = o; cfg_se = s; cfg_stime = TW'(st);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic chk_pins(input string tag, input bit o, input bit s);
    chk(tag, {osc_en, pin1_osc, pin2_osc}, exp_pins(o, s));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Random-phase model state: 0 off, 1 wait, 2 stop, 3 dead
  bit m_off, m_se;
  int m_st, m_ph, m_cnt;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 osc_en/pins", {osc_en, pin1_osc, pin2_osc}, 0);
    chk("R1 stat_good", stat_good, 0);
    chk("R1 stat_off", stat_off, 1);
    chk("R1 readback", {rd_off, rd_se, rd_stime}, {1'b1, 1'b0, TW'(0)});

    // R3/R2/R4 crystal enable, startup 3
    osc_alive = 1'b1;
    wr(0, 0, 3);
    chk_pins("R2 crystal pins", 0, 0);
    chk("R3 stat_off cleared", stat_off, 0);
    chk("R3 rd_stime", rd_stime, 3);
    for (int i = 1; i <= 3; i++) begin
      pulse_tick();
      chk("R4 good withheld", stat_good, 0);
    end
    pulse_tick();
    chk("R4 good on tick N+1", stat_good, 1);

    // R10 direct crystal to single-ended refused
    wr(0, 1, 5);
    chk("R10 se unchanged", rd_se, 0);
    chk("R9 stime kept on reject", rd_stime, 3);

    // R12 / R11 interlocks, then R8 accepted disable
    mclk_hs = 1'b1;
    wr(1, 0, 3);
    chk("R12 disable held", osc_en, 1);
    chk("R12 good kept", stat_good, 1);
    mclk_hs = 1'b0; pll_ref_osc = 1'b1; pll_off = 1'b0;
    wr(1, 0, 3);
    chk("R11 disable held", osc_en, 1);
    pll_off = 1'b1;
    wr(1, 0, 3);
    chk_pins("R2 parked pins", 1, 0);
    chk("R8 good dropped", stat_good, 0);
    chk("R8 off not yet", stat_off, 0);
    pll_ref_osc = 1'b0; pll_off = 1'b0;

    // R9 re-enable refused before off
    wr(1, 1, 0);
    chk("R9 enable ignored", {rd_off, rd_se, osc_en}, 3'b100);
    pulse_tick();
    chk("R8 off waits for dead alive", stat_off, 0);
    osc_alive = 1'b0;
    pulse_tick();
    chk("R8 off after stop", stat_off, 1);

    // R5 single-ended via park, startup 0
    wr(1, 1, 0);
    chk_pins("R2 single-ended off=1 pins", 1, 1);
    chk("R3 single-ended start", stat_off, 0);
    osc_alive = 1'b1;
    chk("R5 not good before tick", stat_good, 0);
    pulse_tick();
    chk("R5 good first tick", stat_good, 1);
    wr(0, 1, 0);
    chk_pins("R2 single-ended off=0 pins", 0, 1);
    chk("R2 good kept in se", stat_good, 1);
    wr(0, 0, 0);
    chk("R10 se to crystal refused", rd_se, 1);

    // R7 dead while good
    osc_alive = 1'b0;
    pulse_tick();
    chk("R7 good over live window", stat_good, 1);
    pulse_tick();
    chk("R7 dead: good", stat_good, 0);
    chk("R7 dead: off", stat_off, 1);
    chk("R7 osc_en kept", osc_en, 1);

    // back to park, wait for off
    wr(1, 0, 0);
    pulse_tick();
    chk("R8 off after park", stat_off, 1);

    // R6 timeout
    wr(0, 0, 2);
    for (int i = 1; i < TMO; i++) pulse_tick();
    chk("R6 before timeout", {stat_off, stat_good}, 0);
    pulse_tick();
    chk("R6 timeout off", {stat_off, stat_good}, 2'b10);
    osc_alive = 1'b1;
    pulse_tick();
    chk("R6 no late good", stat_good, 0);
    osc_alive = 1'b0;

    // Random interlocked writes vs model (R9..R12, R2)
    m_off = 0; m_se = 0; m_st = 2; m_ph = 3; m_cnt = 0;
    for (int it = 0; it < 80; it++) begin
      bit no, ns, acc, soff;
      int st;
      no = 1'($urandom_range(0, 1));
      ns = 1'($urandom_range(0, 1));
      st = int'($urandom_range(0, (1 << TW) - 1));
      mclk_hs     = ($urandom_range(0, 3) == 0);
      pll_ref_osc = ($urandom_range(0, 2) == 0);
      pll_off     = 1'($urandom_range(0, 1));
      soff = (m_ph == 0) || (m_ph == 3);
      acc = exp_accept(m_off, m_se, no, ns, soff, pll_ref_osc, pll_off, mclk_hs);
      wr(no, ns, st);
      if (acc) begin
        if (!is_on(m_off, m_se) && is_on(no, ns)) begin m_ph = 1; m_cnt = 0; end
        else if (is_on(m_off, m_se) && !is_on(no, ns)) m_ph = 2;
        m_off = no; m_se = ns; m_st = st;
      end
      chk("R9 R10 R11 R12 random readback", {rd_off, rd_se, rd_stime}, {m_off, m_se, TW'(m_st)});
      chk_pins("R2 random pins", m_off, m_se);
      chk("R9 random stat_off", stat_off, int'((m_ph == 0) || (m_ph == 3)));
      if ($urandom_range(0, 1) == 1) begin
        pulse_tick();
        if (m_ph == 2) m_ph = 0;
        else if (m_ph == 1) begin
          m_cnt++;
          if (m_cnt == TMO) m_ph = 3;
        end
        chk("R6 R8 random tick stat_off", stat_off, int'((m_ph == 0) || (m_ph == 3)));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd2024);
  end

endmodule